// File: doc/BRIEF.md
# Disk Control Register with Motor One-Shot and Wait-State Generator

This block is the control side of a floppy disk card. The host writes single bits into an 8-bit control register through a bit-addressed port. Each bit position has its own job: it opens the card's memory window, starts the spindle motor, arms the wait logic, loads the heads, picks one of three drives or picks the disk side. A status port, also addressed by bit, reads the same eight positions back.

Two pieces of logic depend on the register. The first is a motor one-shot. It fires only when the motor bit changes from 0 to 1, and it then holds the motor enable for a fixed number of clock cycles. The second is a wait-state generator. It pulls the host READY line low while the host polls the disk controller chip for data and nothing has happened yet. READY returns high as soon as the controller raises its data request or interrupt, the motor window runs out, the arm bit is cleared, or the host moves its address away from the controller chip.

Top module: `floppy_ctl_waitgen`

## Requirements
- R1: A bit write with data 1 to address 0 sets `win_en`, and to address 3 sets `head_load`. A write with data 0 clears the same output. The new value is visible on the clock edge that takes the write.
- R2: A write of 1 to address 1 triggers the motor one-shot only if the last value written to address 1 was 0. The remembered value is 0 after reset. Writing 1 again while the remembered value is 1 leaves the running window unchanged.
- R3: After a trigger, `motor_on` is high for exactly MOTOR_CYCLES clock cycles and then clears by itself. A new trigger while the window is running restarts the full window.
- R4: `ready` is low exactly when all of these hold: `ctl_sel` is high, the wait logic is armed (address 2 holds 1), the synchronised DRQ is low, the synchronised INTRQ is low, and `motor_on` is high. In every other case `ready` is high.
- R5: `drq_in` and `irq_in` each pass through two flip-flops before they reach the READY equation, so a change on either one reaches `ready` two clock edges later. `ctl_sel` reaches `ready` combinationally, in the same cycle.
- R6: A write of 1 to address 4, 5 or 6 sets bit 0, 1 or 2 of `drv_sel`. If that bit was clear and another bit of `drv_sel` was already set, `multi_sel` pulses high for one cycle. The earlier bit stays set.
- R7: A write of 0 to address 4, 5 or 6 clears only the matching bit of `drv_sel`.
- R8: While `rst_n` is low, and right after it rises, the following are all cleared: `win_en`, `head_load`, `drv_sel`, `side_sel`, `motor_on`, `multi_sel`, the arm bit, the remembered motor bit and both synchroniser chains. `ready` is therefore high.
- R9: `st_bit` returns status bit `st_addr` combinationally. Bit 0 is the window enable, bit 1 the motor enable, bit 2 the arm bit, bit 3 head load, bits 4 to 6 the drive mask, and bit 7 the side select.
- R10: A bit write to address 7 sets or clears `side_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bw_en | input | 1 | Bit write strobe |
| bw_addr | input | 3 | Bit address of the write |
| bw_data | input | 1 | Bit value to write |
| st_addr | input | 3 | Bit address of the status read |
| st_bit | output | 1 | Status bit read out |
| ctl_sel | input | 1 | Host address decodes to the controller chip |
| drq_in | input | 1 | Controller data request, asynchronous |
| irq_in | input | 1 | Controller interrupt request, asynchronous |
| win_en | output | 1 | Card memory window enable |
| head_load | output | 1 | Head load |
| drv_sel | output | 3 | Drive select mask |
| side_sel | output | 1 | Disk side select |
| motor_on | output | 1 | Motor enable from the one-shot |
| multi_sel | output | 1 | One-cycle pulse when a second drive is added to the mask |
| ready | output | 1 | Host READY; low inserts wait states |

## Verification
The bench builds the block with MOTOR_CYCLES set to 40 in place of a multi-second count. This makes the whole motor window observable: its last high cycle, the cycle it clears, a retrigger in the middle and a write of 1 that must not retrigger. The window is also long enough to toggle DRQ, INTRQ and `ctl_sel` inside it and check the two-edge synchroniser delay on `ready`.

// File: rtl/fdcw_pkg.sv
package fdcw_pkg;

  localparam int unsigned CTL_BITS = 8;
  localparam int unsigned DRIVES   = 3;

  typedef enum logic [2:0] {
    A_WIN   = 3'd0,
    A_MOTOR = 3'd1,
    A_ARM   = 3'd2,
    A_HEAD  = 3'd3,
    A_DRV0  = 3'd4,
    A_DRV1  = 3'd5,
    A_DRV2  = 3'd6,
    A_SIDE  = 3'd7
  } bit_addr_e;

  // 1 when the address falls in the drive-select range
  function automatic logic is_drive_addr(input logic [2:0] a);
    return (a >= A_DRV0) && (a <= A_DRV2);
  endfunction

  // one-hot drive bit for a drive-select address
  function automatic logic [DRIVES-1:0] drive_onehot(input logic [2:0] a);
    logic [DRIVES-1:0] oh;
    oh = '0;
    for (int i = 0; i < DRIVES; i++)
      if (a == 3'(A_DRV0 + i)) oh[i] = 1'b1;
    return oh;
  endfunction

  // READY level: low only while every stall condition holds
  function automatic logic ready_level(input logic sel, input logic armed,
                                       input logic drq, input logic irq,
                                       input logic motor);
    return !(sel && armed && !drq && !irq && motor);
  endfunction

endpackage

// File: rtl/fdcw_ctlreg.sv
module fdcw_ctlreg
  import fdcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_en,
  input  logic [2:0]        bw_addr,
  input  logic              bw_data,
  output logic              win_en,
  output logic              armed,
  output logic              head_load,
  output logic              side_sel,
  output logic [DRIVES-1:0] drv_mask,
  output logic              motor_trig,
  output logic              multi_evt
);

  logic              last_motor;
  logic              drv_wr;
  logic [DRIVES-1:0] drv_hit;
  logic              adds_second;

  assign drv_wr      = bw_en && is_drive_addr(bw_addr);
  assign drv_hit     = drive_onehot(bw_addr);
  assign adds_second = drv_wr && bw_data && ((drv_mask & drv_hit) == '0)
                       && (drv_mask != '0);
  assign motor_trig  = bw_en && (bw_addr == A_MOTOR) && bw_data && !last_motor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en     <= 1'b0;
      armed      <= 1'b0;
      head_load  <= 1'b0;
      side_sel   <= 1'b0;
      last_motor <= 1'b0;
    end else if (bw_en) begin
      unique case (bw_addr)
        A_WIN:   win_en     <= bw_data;
        A_MOTOR: last_motor <= bw_data;
        A_ARM:   armed      <= bw_data;
        A_HEAD:  head_load  <= bw_data;
        A_SIDE:  side_sel   <= bw_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_mask  <= '0;
      multi_evt <= 1'b0;
    end else begin
      multi_evt <= adds_second;
      if (drv_wr) begin
        if (bw_data) drv_mask <= drv_mask | drv_hit;
        else         drv_mask <= drv_mask & ~drv_hit;
      end
    end
  end

endmodule

// File: rtl/fdcw_oneshot.sv
module fdcw_oneshot #(
  parameter int unsigned MOTOR_CYCLES = 211_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);

  localparam int unsigned CW = $clog2(MOTOR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(MOTOR_CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (trig) begin
      active <= 1'b1;
      remain <= LOAD;
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/fdcw_sync.sv
module fdcw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fdcw_waitgen.sv
module fdcw_waitgen
  import fdcw_pkg::*;
(
  input  logic sel,
  input  logic armed,
  input  logic drq_s,
  input  logic irq_s,
  input  logic motor,
  output logic ready
);

  assign ready = ready_level(sel, armed, drq_s, irq_s, motor);

endmodule

// File: rtl/floppy_ctl_waitgen.sv
module floppy_ctl_waitgen
  import fdcw_pkg::*;
#(
  parameter int unsigned MOTOR_CYCLES = 211_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bw_en,
  input  logic [2:0] bw_addr,
  input  logic       bw_data,
  input  logic [2:0] st_addr,
  output logic       st_bit,
  input  logic       ctl_sel,
  input  logic       drq_in,
  input  logic       irq_in,
  output logic       win_en,
  output logic       head_load,
  output logic [2:0] drv_sel,
  output logic       side_sel,
  output logic       motor_on,
  output logic       multi_sel,
  output logic       ready
);

  logic                armed;
  logic                motor_trig;
  logic                drq_s;
  logic                irq_s;
  logic [CTL_BITS-1:0] status;

  fdcw_ctlreg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bw_en     (bw_en),
    .bw_addr   (bw_addr),
    .bw_data   (bw_data),
    .win_en    (win_en),
    .armed     (armed),
    .head_load (head_load),
    .side_sel  (side_sel),
    .drv_mask  (drv_sel),
    .motor_trig(motor_trig),
    .multi_evt (multi_sel)
  );

  fdcw_oneshot #(.MOTOR_CYCLES(MOTOR_CYCLES)) u_motor (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (motor_trig),
    .active(motor_on)
  );

  fdcw_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({irq_in, drq_in}),
    .q    ({irq_s, drq_s})
  );

  fdcw_waitgen u_wait (
    .sel  (ctl_sel),
    .armed(armed),
    .drq_s(drq_s),
    .irq_s(irq_s),
    .motor(motor_on),
    .ready(ready)
  );

  assign status = {side_sel, drv_sel, head_load, armed, motor_on, win_en};
  assign st_bit = status[st_addr];

endmodule

// File: rtl/fdcw_checker.sv
module fdcw_checker #(
  parameter int unsigned MOTOR_CYCLES = 211_500_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bw_en,
  input logic [2:0] bw_addr,
  input logic       bw_data,
  input logic [2:0] st_addr,
  input logic       st_bit,
  input logic       ctl_sel,
  input logic       side_sel,
  input logic [2:0] drv_sel,
  input logic       motor_on,
  input logic       motor_trig,
  input logic       multi_sel,
  input logic       ready
);

  localparam int unsigned RW = $clog2(MOTOR_CYCLES + 2) + 1;

  logic          shadow_last;
  logic [RW-1:0] run_len;
  logic          wr_one_again;
  logic          drv_clear_wr;

  assign wr_one_again = bw_en && (bw_addr == 3'd1) && bw_data && shadow_last;
  assign drv_clear_wr = bw_en && (bw_addr >= 3'd4) && (bw_addr <= 3'd6) && !bw_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_last <= 1'b0;
      run_len     <= '0;
    end else begin
      if (bw_en && bw_addr == 3'd1) shadow_last <= bw_data;
      if (motor_trig)    run_len <= RW'(1);
      else if (motor_on) run_len <= run_len + 1'b1;
      else               run_len <= '0;
    end
  end

  AST_NO_RETRIGGER_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_one_again |-> !motor_trig); // R2

  AST_MOTOR_RISE_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_on) |-> $past(motor_trig)); // R2

  AST_MOTOR_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    motor_on |-> (run_len >= RW'(1)) && (run_len <= RW'(MOTOR_CYCLES))); // R3

  AST_MOTOR_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(motor_on) |-> (run_len == RW'(MOTOR_CYCLES + 1))); // R3

  AST_STALL_NEEDS_MOTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (motor_on && ctl_sel)); // R4

  AST_MULTI_HAS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    multi_sel |-> ($countones(drv_sel) >= 2)); // R6

  AST_DRIVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    drv_clear_wr |=> !drv_sel[$past(bw_addr[1:0])]); // R7

  AST_SIDE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_addr == 3'd7) |-> (st_bit == side_sel)); // R9

endmodule

bind floppy_ctl_waitgen fdcw_checker #(.MOTOR_CYCLES(MOTOR_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bw_en     (bw_en),
  .bw_addr   (bw_addr),
  .bw_data   (bw_data),
  .st_addr   (st_addr),
  .st_bit    (st_bit),
  .ctl_sel   (ctl_sel),
  .side_sel  (side_sel),
  .drv_sel   (drv_sel),
  .motor_on  (motor_on),
  .motor_trig(motor_trig),
  .multi_sel (multi_sel),
  .ready     (ready)
);

// File: tb/floppy_ctl_waitgen_bench.sv
module floppy_ctl_waitgen_bench;

  localparam int unsigned N = 40;

  // observation vector bit positions
  localparam logic [9:0] O_WIN   = 10'b00_0000_0001;
  localparam logic [9:0] O_HEAD  = 10'b00_0000_0010;
  localparam logic [9:0] O_DRV   = 10'b00_0001_1100;
  localparam logic [9:0] O_SIDE  = 10'b00_0010_0000;
  localparam logic [9:0] O_MOTOR = 10'b00_0100_0000;
  localparam logic [9:0] O_READY = 10'b00_1000_0000;
  localparam logic [9:0] O_MULTI = 10'b01_0000_0000;
  localparam logic [9:0] O_ST    = 10'b10_0000_0000;
  localparam logic [9:0] O_ALL   = 10'b11_1111_1111;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bw_en = 1'b0;
  logic [2:0] bw_addr = '0;
  logic       bw_data = 1'b0;
  logic [2:0] st_addr = '0;
  logic       st_bit;
  logic       ctl_sel = 1'b0;
  logic       drq_in = 1'b0;
  logic       irq_in = 1'b0;
  logic       win_en, head_load, side_sel, motor_on, multi_sel, ready;
  logic [2:0] drv_sel;

  floppy_ctl_waitgen #(.MOTOR_CYCLES(N)) u_floppy_ctl_waitgen (
    .clk(clk), .rst_n(rst_n), .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
    .st_addr(st_addr), .st_bit(st_bit), .ctl_sel(ctl_sel), .drq_in(drq_in),
    .irq_in(irq_in), .win_en(win_en), .head_load(head_load), .drv_sel(drv_sel),
    .side_sel(side_sel), .motor_on(motor_on), .multi_sel(multi_sel), .ready(ready)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [9:0] m;
    logic [9:0] v;
    string      req;
  } exp_t;

  exp_t sb[$];

  function automatic logic [9:0] observe();
    return {st_bit, multi_sel, ready, motor_on, side_sel, drv_sel, head_load, win_en};
  endfunction

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    logic [9:0] o;
    o = observe();
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        n_cmp++;
        if ((o & sb[i].m) !== (sb[i].v & sb[i].m)) begin
          n_bad++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                   sb[i].req, cyc, o & sb[i].m, sb[i].v & sb[i].m, sb[i].m);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(input int at, input logic [9:0] m, input logic [9:0] v,
                           input string req);
    exp_t e;
    e.at = at; e.m = m; e.v = v; e.req = req;
    sb.push_back(e);
  endtask

  // d = 0 means the next falling edge
  task automatic expect_in(input int d, input logic [9:0] m, input logic [9:0] v,
                           input string req);
    expect_at(cyc + d, m, v, req);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic d);
    bw_en = 1'b1; bw_addr = a; bw_data = d;
    step();
    bw_en = 1'b0;
  endtask

  function automatic logic [9:0] drv(input logic [2:0] m);
    return {5'b0, m, 2'b0};
  endfunction

  initial begin
    int t0, t1, t2;
    step(3);
    rst_n = 1'b1;
    expect_in(0, O_ALL, O_READY, "R8 reset state");
    step();

    // R1 window and head load
    wr(3'd0, 1'b1); expect_in(0, O_WIN, O_WIN, "R1 window on");
    wr(3'd3, 1'b1); expect_in(0, O_HEAD, O_HEAD, "R1 head load on");
    st_addr = 3'd3; expect_in(0, O_ST, O_ST, "R9 status head load");
    wr(3'd0, 1'b0); expect_in(0, O_WIN | O_HEAD, O_HEAD, "R1 window off");

    // R10 side select, R9 status bit 7
    wr(3'd7, 1'b1); st_addr = 3'd7;
    expect_in(0, O_SIDE | O_ST, O_SIDE | O_ST, "R10 side set, R9 read");
    wr(3'd7, 1'b0);
    expect_in(0, O_SIDE | O_ST, 10'b0, "R10 side clear, R9 read");

    // R6 / R7 drive mask
    wr(3'd4, 1'b1); expect_in(0, O_DRV | O_MULTI, drv(3'b001), "R6 first drive");
    wr(3'd5, 1'b1); expect_in(0, O_DRV | O_MULTI, drv(3'b011) | O_MULTI, "R6 second drive flags");
    expect_in(1, O_MULTI, 10'b0, "R6 flag is one cycle");
    step();
    wr(3'd5, 1'b1); expect_in(0, O_DRV | O_MULTI, drv(3'b011), "R6 same drive no flag");
    st_addr = 3'd5; expect_in(0, O_ST, O_ST, "R9 status drive bit");
    wr(3'd4, 1'b0); expect_in(0, O_DRV, drv(3'b010), "R7 clear one drive");
    wr(3'd5, 1'b0); expect_in(0, O_DRV, drv(3'b000), "R7 clear last drive");
    wr(3'd6, 1'b1); expect_in(0, O_DRV | O_MULTI, drv(3'b100), "R6 empty mask no flag");
    wr(3'd6, 1'b0);

    // R4 armed but motor off
    wr(3'd2, 1'b1); ctl_sel = 1'b1;
    st_addr = 3'd2; expect_in(0, O_READY | O_ST, O_READY | O_ST, "R4 motor off keeps ready");

    // R2 / R3 motor window
    wr(3'd1, 1'b1); t0 = cyc;
    expect_in(0, O_MOTOR | O_READY, O_MOTOR, "R2 trigger, R4 stall");
    expect_at(t0 + N - 1, O_MOTOR, O_MOTOR, "R3 last high cycle");
    expect_at(t0 + N, O_MOTOR | O_READY, O_READY, "R3 self clear, R2 no retrigger");
    step(2);
    wr(3'd1, 1'b1);                                    // repeated 1: no retrigger
    step();
    drq_in = 1'b1;                                     // R5 two-edge delay
    expect_in(1, O_READY, 10'b0, "R5 drq not yet seen");
    expect_in(2, O_READY, O_READY, "R5 drq releases ready");
    step(4);
    drq_in = 1'b0;
    expect_in(1, O_READY, O_READY, "R5 drq drop not yet seen");
    expect_in(2, O_READY, 10'b0, "R5 stall resumes");
    step(4);
    irq_in = 1'b1;
    expect_in(2, O_READY, O_READY, "R4 irq releases ready");
    step(4);
    irq_in = 1'b0;
    step(4);
    ctl_sel = 1'b0; expect_in(0, O_READY, O_READY, "R5 sel drop same cycle");
    step();
    ctl_sel = 1'b1; expect_in(0, O_READY, 10'b0, "R4 sel back stalls");
    step(t0 + N + 2 - cyc);

    // R3 retrigger restarts window
    wr(3'd1, 1'b0);
    wr(3'd1, 1'b1); t1 = cyc;
    expect_in(0, O_MOTOR, O_MOTOR, "R2 rising write triggers");
    step(5);
    wr(3'd1, 1'b0);
    wr(3'd1, 1'b1); t2 = cyc;
    expect_at(t1 + N, O_MOTOR, O_MOTOR, "R3 retrigger extends");
    expect_at(t2 + N, O_MOTOR, 10'b0, "R3 retriggered window ends");
    wr(3'd2, 1'b0); expect_in(0, O_READY, O_READY, "R4 disarm releases ready");
    wr(3'd2, 1'b1); expect_in(0, O_READY, 10'b0, "R4 rearm stalls");
    step(t2 + N + 2 - cyc);

    // R8 reset in mid run
    wr(3'd0, 1'b1); wr(3'd4, 1'b1); wr(3'd7, 1'b1); wr(3'd1, 1'b0); wr(3'd1, 1'b1);
    rst_n = 1'b0;
    st_addr = 3'd2;
    expect_in(0, O_ALL, O_READY, "R8 reset clears all");
    step(2);
    rst_n = 1'b1;
    step();
    wr(3'd1, 1'b1);
    expect_in(0, O_MOTOR, O_MOTOR, "R8 remembered motor bit cleared");
    step(N + 5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc == 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule